// File: doc/BRIEF.md
# Locked-Sequence Exclusive Access Monitor

This block sits beside a memory array and watches the accesses of one locking master together with those of several other masters. The locking master marks the read and the write of an indivisible read-modify-write sequence with a lock flag. A locked read arms a reservation on its address. Any access by another master before the matching locked write cancels that reservation, whatever address it targets.

For each locked write, the monitor decides in the write's address phase whether the reservation is still intact and aimed at the same address. In the following cycle, which is the write's data phase, it returns a one-cycle status to the locking master: ok high for success, ok low for failure. In the same cycle it drives the commit port of the memory. A failed locked write never reaches the memory. Unlocked writes from the locking master always pass through to memory and produce no status.

Top module: `lockseq_monitor`

## Requirements
- R1: A locked read (`lm_valid`=1, `lm_write`=0, `lm_lock`=1) in a cycle with no `om_valid` bit set arms a reservation holding `lm_addr`.
- R2: A locked write (`lm_valid`=1, `lm_write`=1, `lm_lock`=1) to the reserved address, with the reservation intact, gives `st_valid`=1 and `st_ok`=1 in the next cycle. In that same cycle it gives `mem_we`=1 with `mem_addr`/`mem_wdata` equal to the write's address and data.
- R3: If any `om_valid` bit is high in any cycle after the arming read, up to and including the locked write's own address-phase cycle, the write reports `st_valid`=1, `st_ok`=0.
- R4: A locked write whose address differs from the reserved one, or that finds no reservation, reports `st_valid`=1, `st_ok`=0.
- R5: A locked write reported as failed is not committed: `mem_we`=0 in its data-phase cycle.
- R6: Every locked write clears the reservation, whether it succeeds or fails.
- R7: A locked read in a cycle where some `om_valid` bit is high leaves no reservation, so the following locked write fails.
- R8: A second locked read before any write replaces the reserved address with its own.
- R9: Unlocked reads and writes by the locking master leave the reservation unchanged and produce no status. An unlocked write is always committed one cycle later.
- R10: Reset clears the reservation and drives `st_valid`, `st_ok` and `mem_we` low.
- R11: `st_valid` is high only in the cycle that follows a locked write's address phase, and `st_ok` is never high without `st_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lm_valid | input | 1 | Locking master address phase valid |
| lm_write | input | 1 | Locking master access is a write |
| lm_lock | input | 1 | Access belongs to an indivisible sequence |
| lm_addr | input | AW (8) | Locking master address |
| lm_wdata | input | DW (16) | Locking master write data |
| om_valid | input | N_OTHERS (3) | One access-valid bit per other master |
| st_valid | output | 1 | Locked-write status present (data phase) |
| st_ok | output | 1 | 1 = exclusive write succeeded, 0 = failed |
| mem_we | output | 1 | Memory commit strobe |
| mem_addr | output | AW (8) | Commit address |
| mem_wdata | output | DW (16) | Commit data |

## Verification
The bound checker checks on every cycle that a locked write is always followed by a status, and that an intervening access or a missing reservation forces a failure. It also checks that a failure never commits, that locked writes drop the reservation, and that a clean locked read arms it with the right address. Other behaviours only the bench's scenarios can show: the end-to-end effect on memory contents, the replacement of an armed address by a later locked read, the neutrality of the locking master's own unlocked traffic, and the loss of a reservation across reset.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_PLAIN_RD = 3'd1,
    K_PLAIN_WR = 3'd2,
    K_LOCK_RD  = 3'd3,
    K_LOCK_WR  = 3'd4
  } lm_kind_e;

  // Classify one address phase of the locking master.
  function automatic lm_kind_e classify(input logic valid, input logic write,
                                        input logic lock);
    if (!valid)               return K_NONE;
    else if (write && lock)   return K_LOCK_WR;
    else if (write)           return K_PLAIN_WR;
    else if (lock)            return K_LOCK_RD;
    else                      return K_PLAIN_RD;
  endfunction

  // A locked write succeeds only on an intact, matching reservation with no
  // competing access in its own address phase.
  function automatic logic judge(input logic res_valid, input logic addr_match,
                                 input logic intervene);
    return res_valid && addr_match && !intervene;
  endfunction

endpackage

// File: rtl/lockseq_intervene.sv
module lockseq_intervene #(
  parameter int N_OTHERS = 3
) (
  input  logic [N_OTHERS-1:0] om_valid,
  output logic                any_access
);
  logic [N_OTHERS:0] chain;
  assign chain[0] = 1'b0;
  generate
    for (genvar i = 0; i < N_OTHERS; i++) begin : g_or
      assign chain[i+1] = chain[i] | om_valid[i];
    end
  endgenerate
  assign any_access = chain[N_OTHERS];
endmodule

// File: rtl/lockseq_reservation.sv
module lockseq_reservation #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          drop,
  input  logic          kill,
  input  logic [AW-1:0] arm_addr,
  output logic          res_valid,
  output logic [AW-1:0] res_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
    end else if (arm) begin
      res_valid <= 1'b1;
      res_addr  <= arm_addr;
    end else if (drop || kill) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lockseq_respond.sv
module lockseq_respond #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_wr,
  input  logic          plain_wr,
  input  logic          pass,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          st_valid,
  output logic          st_ok,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic commit;
  assign commit = plain_wr || (lock_wr && pass);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid  <= 1'b0;
      st_ok     <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      st_valid <= lock_wr;
      st_ok    <= lock_wr && pass;
      mem_we   <= commit;
      if (commit) begin
        mem_addr  <= wr_addr;
        mem_wdata <= wr_data;
      end
    end
  end
endmodule

// File: rtl/lockseq_monitor.sv
module lockseq_monitor #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int N_OTHERS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lm_valid,
  input  logic                lm_write,
  input  logic                lm_lock,
  input  logic [AW-1:0]       lm_addr,
  input  logic [DW-1:0]       lm_wdata,
  input  logic [N_OTHERS-1:0] om_valid,
  output logic                st_valid,
  output logic                st_ok,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata
);
  import lockseq_pkg::*;

  lm_kind_e      kind;
  logic          ev_lock_rd, ev_lock_wr, ev_plain_wr;
  logic          ev_intervene, ev_arm, ev_match, ev_pass;
  logic          res_valid;
  logic [AW-1:0] res_addr;

  assign kind        = classify(lm_valid, lm_write, lm_lock);
  assign ev_lock_rd  = (kind == K_LOCK_RD);
  assign ev_lock_wr  = (kind == K_LOCK_WR);
  assign ev_plain_wr = (kind == K_PLAIN_WR);

  lockseq_intervene #(.N_OTHERS(N_OTHERS)) u_intervene (
    .om_valid   (om_valid),
    .any_access (ev_intervene)
  );

  assign ev_arm   = ev_lock_rd && !ev_intervene;
  assign ev_match = (res_addr == lm_addr);
  assign ev_pass  = judge(res_valid, ev_match, ev_intervene);

  lockseq_reservation #(.AW(AW)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (ev_arm),
    .drop      (ev_lock_wr),
    .kill      (ev_intervene),
    .arm_addr  (lm_addr),
    .res_valid (res_valid),
    .res_addr  (res_addr)
  );

  lockseq_respond #(.AW(AW), .DW(DW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_wr   (ev_lock_wr),
    .plain_wr  (ev_plain_wr),
    .pass      (ev_pass),
    .wr_addr   (lm_addr),
    .wr_data   (lm_wdata),
    .st_valid  (st_valid),
    .st_ok     (st_ok),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );
endmodule

// File: rtl/lockseq_monitor_chk.sv
module lockseq_monitor_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_lock_rd,
  input logic          ev_lock_wr,
  input logic          ev_plain_wr,
  input logic          ev_intervene,
  input logic          res_valid,
  input logic [AW-1:0] res_addr,
  input logic [AW-1:0] lm_addr,
  input logic          st_valid,
  input logic          st_ok,
  input logic          mem_we
);
  AST_ARM_ON_CLEAN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_rd && !ev_intervene |=> res_valid && res_addr == $past(lm_addr)); // R1
  AST_OK_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    st_ok |-> mem_we); // R2
  AST_INTERVENE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_wr && ev_intervene |=> st_valid && !st_ok); // R3
  AST_NO_RESV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_wr && !res_valid |=> !st_ok); // R4
  AST_FAIL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ok |-> !mem_we); // R5
  AST_WRITE_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_wr |=> !res_valid); // R6
  AST_DIRTY_READ_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_rd && ev_intervene |=> !res_valid); // R7
  AST_PLAIN_WR_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_plain_wr |=> mem_we && !st_valid); // R9
  AST_STATUS_AFTER_LOCKED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_wr |=> st_valid); // R11
  AST_STATUS_ONLY_AFTER_LOCKED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_lock_wr |=> !st_valid); // R11
  AST_OK_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    st_ok |-> st_valid); // R11
endmodule

bind lockseq_monitor lockseq_monitor_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_lock_rd   (ev_lock_rd),
  .ev_lock_wr   (ev_lock_wr),
  .ev_plain_wr  (ev_plain_wr),
  .ev_intervene (ev_intervene),
  .res_valid    (res_valid),
  .res_addr     (res_addr),
  .lm_addr      (lm_addr),
  .st_valid     (st_valid),
  .st_ok        (st_ok),
  .mem_we       (mem_we)
);

// File: tb/lockseq_monitor_test.sv
`timescale 1ns/1ps
module lockseq_monitor_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NO = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lm_valid, lm_write, lm_lock;
  logic [AW-1:0] lm_addr;
  logic [DW-1:0] lm_wdata;
  logic [NO-1:0] om_valid;
  logic          st_valid, st_ok, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  lockseq_monitor #(.AW(AW), .DW(DW), .N_OTHERS(NO)) uut (
    .clk(clk), .rst_n(rst_n), .lm_valid(lm_valid), .lm_write(lm_write),
    .lm_lock(lm_lock), .lm_addr(lm_addr), .lm_wdata(lm_wdata),
    .om_valid(om_valid), .st_valid(st_valid), .st_ok(st_ok),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // Small memory fed by the commit port.
  logic [DW-1:0] mem [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  typedef struct packed {
    logic          v, w, l;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [NO-1:0] om;
    logic          e_sv, e_ok, e_we;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,8'h00,16'h0000,3'b000,1'b0,1'b0,1'b0}, // idle, R11
    '{1'b1,1'b0,1'b1,8'h10,16'h0000,3'b000,1'b0,1'b0,1'b0}, // locked read, R1
    '{1'b1,1'b1,1'b1,8'h10,16'h1111,3'b000,1'b1,1'b1,1'b1}, // success, R2
    '{1'b1,1'b1,1'b1,8'h10,16'h1112,3'b000,1'b1,1'b0,1'b0}, // cleared, R6
    '{1'b1,1'b0,1'b1,8'h20,16'h0000,3'b000,1'b0,1'b0,1'b0}, // arm, R1
    '{1'b0,1'b0,1'b0,8'h00,16'h0000,3'b001,1'b0,1'b0,1'b0}, // other access, R3
    '{1'b1,1'b1,1'b1,8'h20,16'h2222,3'b000,1'b1,1'b0,1'b0}, // fail, R3 R5
    '{1'b1,1'b0,1'b1,8'h30,16'h0000,3'b000,1'b0,1'b0,1'b0}, // arm
    '{1'b1,1'b1,1'b1,8'h31,16'h3333,3'b000,1'b1,1'b0,1'b0}, // mismatch, R4
    '{1'b1,1'b0,1'b1,8'h40,16'h0000,3'b000,1'b0,1'b0,1'b0}, // arm
    '{1'b1,1'b1,1'b1,8'h40,16'h4444,3'b100,1'b1,1'b0,1'b0}, // same-cycle other, R3
    '{1'b1,1'b0,1'b1,8'h50,16'h0000,3'b010,1'b0,1'b0,1'b0}, // dirty read, R7
    '{1'b1,1'b1,1'b1,8'h50,16'h5555,3'b000,1'b1,1'b0,1'b0}, // R7
    '{1'b1,1'b0,1'b1,8'h60,16'h0000,3'b000,1'b0,1'b0,1'b0}, // arm
    '{1'b1,1'b0,1'b0,8'h70,16'h0000,3'b000,1'b0,1'b0,1'b0}, // plain read, R9
    '{1'b1,1'b1,1'b0,8'h71,16'h7171,3'b000,1'b0,1'b0,1'b1}, // plain write, R9
    '{1'b1,1'b1,1'b1,8'h60,16'h6666,3'b000,1'b1,1'b1,1'b1}, // still intact, R9
    '{1'b1,1'b0,1'b1,8'h80,16'h0000,3'b000,1'b0,1'b0,1'b0}, // arm 0x80
    '{1'b1,1'b0,1'b1,8'h90,16'h0000,3'b000,1'b0,1'b0,1'b0}, // replace, R8
    '{1'b1,1'b1,1'b1,8'h80,16'h8888,3'b000,1'b1,1'b0,1'b0}, // old addr fails, R8
    '{1'b1,1'b1,1'b1,8'h90,16'h9999,3'b000,1'b1,1'b0,1'b0}, // no reservation, R4
    '{1'b1,1'b1,1'b0,8'hA5,16'hA5A5,3'b111,1'b0,1'b0,1'b1}  // plain write with others, R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge capture, sample just after it.
  task automatic apply(input logic v, input logic w, input logic l,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NO-1:0] om);
    @(negedge clk);
    lm_valid = v; lm_write = w; lm_lock = l; lm_addr = a; lm_wdata = d; om_valid = om;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    lm_valid = 0; lm_write = 0; lm_lock = 0; lm_addr = '0; lm_wdata = '0; om_valid = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 st_valid at reset", st_valid, 0);
    chk("R10 st_ok at reset", st_ok, 0);
    chk("R10 mem_we at reset", mem_we, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].v, VEC[i].w, VEC[i].l, VEC[i].a, VEC[i].d, VEC[i].om);
      chk($sformatf("vector %0d st_valid (R2 R3 R4 R11)", i), st_valid, VEC[i].e_sv);
      chk($sformatf("vector %0d st_ok (R2 R3 R4)", i), st_ok, VEC[i].e_ok);
      chk($sformatf("vector %0d mem_we (R5 R9)", i), mem_we, VEC[i].e_we);
      if (VEC[i].e_we) begin
        chk($sformatf("vector %0d mem_addr R2", i), mem_addr, VEC[i].a);
        chk($sformatf("vector %0d mem_wdata R2", i), mem_wdata, VEC[i].d);
      end
    end
    apply(0, 0, 0, '0, '0, '0);

    // Memory contents after the table.
    chk("R2 committed locked write", mem[8'h10], 16'h1111);
    chk("R6 second write not committed", mem[8'h10] == 16'h1112, 0);
    chk("R5 failed write left memory", mem[8'h20], 16'h0000);
    chk("R5 same-cycle intervene left memory", mem[8'h40], 16'h0000);
    chk("R9 plain write committed", mem[8'h71], 16'h7171);
    chk("R9 plain write with others committed", mem[8'hA5], 16'hA5A5);
    chk("R8 replaced address not written", mem[8'h80], 16'h0000);

    // Reset drops an armed reservation.
    apply(1, 0, 1, 8'hC0, '0, '0);
    @(negedge clk);
    rst_n = 1'b0;
    lm_valid = 0; om_valid = '0;
    @(posedge clk);
    #1;
    chk("R10 outputs low in reset", {st_valid, st_ok, mem_we}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    apply(1, 1, 1, 8'hC0, 16'hC0C0, '0);
    chk("R10 status after reset", st_valid, 1);
    chk("R10 write fails after reset", st_ok, 0);
    chk("R10 no commit", mem_we, 0);

    // A reservation survives idle cycles; the status is a single pulse.
    apply(1, 0, 1, 8'hD0, '0, '0);
    apply(0, 0, 0, '0, '0, '0);
    apply(0, 0, 0, '0, '0, '0);
    apply(1, 1, 1, 8'hD0, 16'hD0D0, '0);
    chk("R2 ok after idle gap", st_ok, 1);
    apply(0, 0, 0, '0, '0, '0);
    chk("R11 status single cycle", st_valid, 0);
    chk("R11 ok drops", st_ok, 0);
    chk("R2 memory holds data", mem[8'hD0], 16'hD0D0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule